// File: doc/BRIEF.md
# CCD Pixel Region and Colour Tagger

This block watches a digitised CCD sample stream that delivers one sample per pixel clock, with a line-start strobe on the first clock of every line and a frame-start strobe that accompanies the line start of the first line of a frame. For each sample it reports the region of the sensor the sample comes from (horizontal or vertical dummy, optical black, effective image, or blanking) and the position of the sample in the Bayer colour mosaic. Red and blue lines alternate; the green sample on a red line is tagged differently from the green sample on a blue line.

Every line ends with a run of light-shielded pixels. The block averages the first power-of-two group of them into a black level for that line, and subtracts this level from the effective pixels of the following line. The result is floored at zero and published with a valid strobe that is raised only for effective pixels. All outputs follow their input sample by one clock. The default geometry is a 780-clock line made of 16 dummy clocks, 2 leading black pixels, 659 effective pixels, 31 trailing black pixels and blanking. The default frame has 525 lines: 5 dummy lines, 8 leading black lines, 494 effective lines, 2 trailing black lines and blanking.

Top module: `ccd_pixel_tagger`

## Requirements
- R1: Within a line, the column counted from the line-start sample (column 0) is classified in this order: H_DUMMY dummy columns, H_LEAD black columns, H_ACT effective columns, H_TRAIL black columns, then blanking up to the end of the line. The region codes are 0 blanking, 1 dummy, 2 optical black and 3 effective.
- R2: Within a frame, the line counted from the line that carries frame start (line 0) is classified in this order: V_DUMMY dummy lines, V_LEAD black lines, V_ACT effective lines, V_TRAIL black lines, then blanking. The reported region is the lower of the two axis codes.
- R3: The colour code is 0 for R, 1 for Gr, 2 for Gb and 3 for B. Bit 1 is the parity of the line offset from the first effective line, and bit 0 is the parity of the column offset from the first effective column. Colour is therefore R at the first effective line and column.
- R4: out_valid is 1 exactly when the region is effective. While out_valid is 0, out_pix is 0.
- R5: The black level is the sum of the samples in the first N_AVG trailing black columns of a line, shifted right by log2(N_AVG). It appears on out_black after the next line start and stays constant otherwise. It is 0 after reset.
- R6: For an effective pixel, out_pix is the sample minus the current black level, and is 0 when the sample is below that level.
- R7: Every output reflects the sample presented one clock edge earlier.
- R8: The column count saturates at LINE_CLKS when no line start arrives, and the line count saturates at FRAME_LINES when no frame start arrives. Both saturated positions classify as blanking. frame start is honoured only together with line start.
- R9: During and after reset, region, colour, valid, pixel and black level are 0. Both counts sit at their saturated values until the first line start and the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Digitised sample |
| in_line_start | input | 1 | First sample of a line |
| in_frame_start | input | 1 | With line start: first line of a frame |
| out_region | output | 2 | Region code (R1) |
| out_color | output | 2 | Bayer colour code (R3) |
| out_valid | output | 1 | Effective pixel strobe |
| out_pix | output | DW | Black-corrected effective pixel |
| out_black | output | DW | Black level in use |

## Verification
The bench builds the block with a shrunken geometry: a 30-clock line made of 4 dummy, 2 black, 10 effective and 8 trailing black columns, a 16-line frame made of 2 dummy, 3 black, 6 effective and 2 trailing black lines, N_AVG of 4 and 10-bit samples. With this geometry every region boundary, both colour phases, many black-level updates, and several frames fit in a few thousand clocks. Lines that are made shorter or longer than the nominal length, and runs of lines without a frame start, drive both counters into saturation. Black-pixel levels at full scale and at zero reach both ends of the subtraction, including the zero floor.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

   typedef enum logic [1:0] {
      RG_BLANK  = 2'd0,
      RG_DUMMY  = 2'd1,
      RG_BLACK  = 2'd2,
      RG_ACTIVE = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      CF_RED   = 2'd0,
      CF_GRN_R = 2'd1,
      CF_GRN_B = 2'd2,
      CF_BLUE  = 2'd3
   } cfa_e;

   // The two axes combine by taking the lower code: blanking wins over dummy,
   // dummy over black, black over effective.
   function automatic region_e region_min(region_e a, region_e b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/ccd_axis_classifier.sv
module ccd_axis_classifier
   import ccd_tag_pkg::*;
#(
   parameter int PW        = 10,
   parameter int SEG_DUMMY = 16,
   parameter int SEG_LEAD  = 2,
   parameter int SEG_ACT   = 659,
   parameter int SEG_TRAIL = 31
) (
   input  logic [PW-1:0] pos,
   output region_e       cls,
   output logic          phase
);

   localparam int LEAD_AT  = SEG_DUMMY;
   localparam int ACT_AT   = LEAD_AT + SEG_LEAD;
   localparam int TRAIL_AT = ACT_AT + SEG_ACT;
   localparam int END_AT   = TRAIL_AT + SEG_TRAIL;

   localparam logic [PW-1:0] B_LEAD  = PW'(LEAD_AT);
   localparam logic [PW-1:0] B_ACT   = PW'(ACT_AT);
   localparam logic [PW-1:0] B_TRAIL = PW'(TRAIL_AT);
   localparam logic [PW-1:0] B_END   = PW'(END_AT);

   if (END_AT >= (1 << PW)) begin : g_bad_span
      $error("axis segments exceed the position width");
   end

   logic in_dummy;

   if (SEG_DUMMY > 0) begin : g_dummy
      assign in_dummy = (pos < B_LEAD);
   end else begin : g_no_dummy
      assign in_dummy = 1'b0;
   end

   always_comb begin
      if (in_dummy)              cls = RG_DUMMY;
      else if (pos < B_ACT)      cls = RG_BLACK;
      else if (pos < B_TRAIL)    cls = RG_ACTIVE;
      else if (pos < B_END)      cls = RG_BLACK;
      else                       cls = RG_BLANK;
   end

   // parity of (pos - first effective position)
   assign phase = pos[0] ^ B_ACT[0];

endmodule

// File: rtl/ccd_raster_counter.sv
module ccd_raster_counter #(
   parameter int LINE_CLKS   = 780,
   parameter int FRAME_LINES = 525,
   parameter int CW          = 10,
   parameter int RW          = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_start,
   input  logic          frame_start,
   output logic [CW-1:0] col,
   output logic [RW-1:0] row
);

   localparam logic [CW-1:0] COL_SAT = CW'(LINE_CLKS);
   localparam logic [RW-1:0] ROW_SAT = RW'(FRAME_LINES);

   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;

   always_comb begin
      if (line_start)            col = '0;
      else if (col_q == COL_SAT) col = col_q;
      else                       col = col_q + 1'b1;

      if (line_start && frame_start)          row = '0;
      else if (line_start && row_q != ROW_SAT) row = row_q + 1'b1;
      else                                    row = row_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= COL_SAT;
         row_q <= ROW_SAT;
      end else begin
         col_q <= col;
         row_q <= row;
      end
   end

endmodule

// File: rtl/ccd_black_estimator.sv
module ccd_black_estimator #(
   parameter int DW     = 12,
   parameter int CW     = 10,
   parameter int WIN_AT = 677,
   parameter int N_AVG  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_start,
   input  logic [CW-1:0] col,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] level
);

   localparam int SH = $clog2(N_AVG);
   localparam int AW = DW + SH;
   localparam logic [CW-1:0] W_LO = CW'(WIN_AT);
   localparam logic [CW-1:0] W_HI = CW'(WIN_AT + N_AVG);

   logic [AW-1:0] acc_q;
   logic [DW-1:0] level_q;
   logic          in_win;

   assign in_win = (col >= W_LO) && (col < W_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         level_q <= '0;
      end else if (line_start) begin
         level_q <= DW'(acc_q >> SH);
         acc_q   <= '0;
      end else if (in_win) begin
         acc_q   <= acc_q + AW'(data);
      end
   end

   assign level = level_q;

endmodule

// File: rtl/ccd_pixel_tagger.sv
module ccd_pixel_tagger
   import ccd_tag_pkg::*;
#(
   parameter int DW          = 12,
   parameter int H_DUMMY     = 16,
   parameter int H_LEAD      = 2,
   parameter int H_ACT       = 659,
   parameter int H_TRAIL     = 31,
   parameter int LINE_CLKS   = 780,
   parameter int V_DUMMY     = 5,
   parameter int V_LEAD      = 8,
   parameter int V_ACT       = 494,
   parameter int V_TRAIL     = 2,
   parameter int FRAME_LINES = 525,
   parameter int N_AVG       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] in_data,
   input  logic          in_line_start,
   input  logic          in_frame_start,
   output logic [1:0]    out_region,
   output logic [1:0]    out_color,
   output logic          out_valid,
   output logic [DW-1:0] out_pix,
   output logic [DW-1:0] out_black
);

   localparam int CW     = $clog2(LINE_CLKS + 1);
   localparam int RW     = $clog2(FRAME_LINES + 1);
   localparam int WIN_AT = H_DUMMY + H_LEAD + H_ACT;
   localparam int H_END  = WIN_AT + H_TRAIL;
   localparam int V_END  = V_DUMMY + V_LEAD + V_ACT + V_TRAIL;

   if (N_AVG < 1 || (N_AVG & (N_AVG - 1)) != 0) begin : g_bad_avg
      $error("N_AVG must be a power of two");
   end
   if (N_AVG > H_TRAIL) begin : g_bad_win
      $error("N_AVG exceeds the trailing black run");
   end
   if (H_END > LINE_CLKS || WIN_AT < 1) begin : g_bad_line
      $error("horizontal segments do not fit the line");
   end
   if (V_END > FRAME_LINES) begin : g_bad_frame
      $error("vertical segments do not fit the frame");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW too small");
   end

   logic [CW-1:0] col;
   logic [RW-1:0] row;
   region_e       h_cls, v_cls, reg_n;
   logic          h_ph, v_ph;
   logic [DW-1:0] black;
   logic [DW:0]   diff;
   logic [DW-1:0] corr;

   ccd_raster_counter #(
      .LINE_CLKS  (LINE_CLKS),
      .FRAME_LINES(FRAME_LINES),
      .CW         (CW),
      .RW         (RW)
   ) u_raster (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (in_line_start),
      .frame_start(in_frame_start),
      .col        (col),
      .row        (row)
   );

   ccd_axis_classifier #(
      .PW       (CW),
      .SEG_DUMMY(H_DUMMY),
      .SEG_LEAD (H_LEAD),
      .SEG_ACT  (H_ACT),
      .SEG_TRAIL(H_TRAIL)
   ) u_hcls (
      .pos  (col),
      .cls  (h_cls),
      .phase(h_ph)
   );

   ccd_axis_classifier #(
      .PW       (RW),
      .SEG_DUMMY(V_DUMMY),
      .SEG_LEAD (V_LEAD),
      .SEG_ACT  (V_ACT),
      .SEG_TRAIL(V_TRAIL)
   ) u_vcls (
      .pos  (row),
      .cls  (v_cls),
      .phase(v_ph)
   );

   ccd_black_estimator #(
      .DW    (DW),
      .CW    (CW),
      .WIN_AT(WIN_AT),
      .N_AVG (N_AVG)
   ) u_black (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_start(in_line_start),
      .col       (col),
      .data      (in_data),
      .level     (black)
   );

   assign reg_n = region_min(h_cls, v_cls);
   assign diff  = {1'b0, in_data} - {1'b0, black};
   assign corr  = diff[DW] ? '0 : diff[DW-1:0];

   region_e       region_q;
   logic [1:0]    color_q;
   logic          valid_q;
   logic [DW-1:0] pix_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         region_q <= RG_BLANK;
         color_q  <= '0;
         valid_q  <= 1'b0;
         pix_q    <= '0;
      end else begin
         region_q <= reg_n;
         color_q  <= {v_ph, h_ph};
         valid_q  <= (reg_n == RG_ACTIVE);
         pix_q    <= (reg_n == RG_ACTIVE) ? corr : '0;
      end
   end

   assign out_region = region_q;
   assign out_color  = color_q;
   assign out_valid  = valid_q;
   assign out_pix    = pix_q;
   assign out_black  = black;

endmodule

// File: rtl/ccd_pixel_tagger_chk.sv
module ccd_pixel_tagger_chk #(
   parameter int DW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_line_start,
   input logic [DW-1:0] in_data,
   input logic [1:0]    out_region,
   input logic [1:0]    out_color,
   input logic          out_valid,
   input logic [DW-1:0] out_pix,
   input logic [DW-1:0] out_black
);

   // column 0 of any line is never effective
   assert_col0_not_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_line_start |=> (out_region != 2'd3));

   assert_quiet_when_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_pix == '0));

   assert_black_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_line_start) |-> $stable(out_black));

   assert_floor_not_above_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_pix <= $past(in_data)));

   assert_column_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_color[0] != $past(out_color[0])));

   assert_row_phase_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_color[1] == $past(out_color[1])));

endmodule

bind ccd_pixel_tagger ccd_pixel_tagger_chk #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_line_start(in_line_start),
   .in_data      (in_data),
   .out_region   (out_region),
   .out_color    (out_color),
   .out_valid    (out_valid),
   .out_pix      (out_pix),
   .out_black    (out_black)
);

// File: tb/sim_ccd_pixel_tagger.sv
module sim_ccd_pixel_tagger;

   localparam int CLK_PERIOD = 10;
   localparam int DW      = 10;
   localparam int HD = 4, HL = 2, HA = 10, HT = 8, LINE = 30;
   localparam int VD = 2, VL = 3, VA = 6, VT = 2, FRAME = 16;
   localparam int NAVG = 4;
   localparam int SH   = 2;
   localparam int WIN  = HD + HL + HA;
   localparam int MAXV = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_line_start = 1'b0;
   logic          in_frame_start = 1'b0;
   logic [1:0]    out_region, out_color;
   logic          out_valid;
   logic [DW-1:0] out_pix, out_black;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   int m_col, m_row, m_acc, m_blk, prev_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccd_pixel_tagger #(
      .DW(DW), .H_DUMMY(HD), .H_LEAD(HL), .H_ACT(HA), .H_TRAIL(HT), .LINE_CLKS(LINE),
      .V_DUMMY(VD), .V_LEAD(VL), .V_ACT(VA), .V_TRAIL(VT), .FRAME_LINES(FRAME), .N_AVG(NAVG)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_line_start(in_line_start),
      .in_frame_start(in_frame_start), .out_region(out_region), .out_color(out_color),
      .out_valid(out_valid), .out_pix(out_pix), .out_black(out_black)
   );

   function automatic int cls_of(int p, int d, int l, int a, int t);
      if (p < d)             return 1;
      if (p < d + l)         return 2;
      if (p < d + l + a)     return 3;
      if (p < d + l + a + t) return 2;
      return 0;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_col = LINE; m_row = FRAME; m_acc = 0; m_blk = 0; prev_valid = 0;
   endtask

   // R9: reset behaviour, caller is at a negedge
   task automatic do_reset();
      rst_n = 1'b0; in_line_start = 1'b0; in_frame_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 region", int'(out_region), 0);
      chk("R9 colour", int'(out_color), 0);
      chk("R9 valid", int'(out_valid), 0);
      chk("R9 pix", int'(out_pix), 0);
      chk("R9 black", int'(out_black), 0);
      rst_n = 1'b1;
      model_reset();
   endtask

   // drive one sample at a negedge, check its results one edge later
   task automatic step(bit ls, bit fs, int data);
      int hc, vc, rg, col_e, pix_e;
      string rreq;
      in_line_start  = ls;
      in_frame_start = fs;
      in_data        = DW'(data);
      if (ls) begin
         m_col = 0;
         if (fs) m_row = 0;
         else if (m_row < FRAME) m_row++;
         m_blk = m_acc >> SH;
         m_acc = 0;
      end else if (m_col < LINE) m_col++;
      hc = cls_of(m_col, HD, HL, HA, HT);
      vc = cls_of(m_row, VD, VL, VA, VT);
      rg = (hc < vc) ? hc : vc;
      col_e = (((m_row - (VD + VL)) & 1) << 1) | ((m_col - (HD + HL)) & 1);
      pix_e = (rg == 3) ? ((data > m_blk) ? data - m_blk : 0) : 0;
      if (m_col >= WIN && m_col < WIN + NAVG) m_acc += data;
      if (m_col >= LINE || m_row >= FRAME) rreq = "R8 region";
      else if (hc <= vc)                    rreq = "R1 region";
      else                                  rreq = "R2 region";
      // R7: before the edge the output still shows the previous sample
      chk("R7 valid before edge", int'(out_valid), prev_valid);
      @(posedge clk);
      @(negedge clk);
      chk(rreq, int'(out_region), rg);
      chk("R3 colour", int'(out_color), col_e);
      chk("R4 valid", int'(out_valid), (rg == 3) ? 1 : 0);
      chk((rg == 3) ? "R6 pix" : "R4 pix", int'(out_pix), pix_e);
      chk("R5 black", int'(out_black), m_blk);
      prev_valid = (rg == 3) ? 1 : 0;
   endtask

   // mode 0: random black level, 1: full-scale black, 2: zero black
   task automatic run_line(bit fs, int len, int mode);
      int ob_lvl = (mode == 1) ? MAXV : (mode == 2) ? 0 : int'($urandom % 512);
      for (int c = 0; c < len; c++) begin
         int d;
         if (c >= WIN && c < WIN + NAVG)
            d = ob_lvl + ((mode == 0) ? int'($urandom % 8) : 0);
         else if (($urandom % 4) == 0)
            d = int'($urandom % 64);
         else
            d = int'($urandom % (MAXV + 1));
         step(c == 0, fs && (c == 0), d);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();
      // R8: no line start yet, and a line with no frame start: all blanking
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 100);
      run_line(1'b0, LINE, 0);
      // regular frames with random line lengths
      for (int f = 0; f < 4; f++) begin
         for (int l = 0; l < FRAME; l++) begin
            int r = int'($urandom % 8);
            int len = (r == 0) ? LINE + 5 : (r == 1) ? WIN + NAVG + 2 : LINE;
            int mode = (l == 6) ? 1 : (l == 9) ? 2 : 0;
            run_line(l == 0, len, mode);
         end
      end
      // R8: lines past the frame end without a frame start
      for (int l = 0; l < FRAME + 3; l++) run_line(l == 0, LINE, 0);
      // R6 extremes inside the effective lines
      for (int l = 0; l < FRAME; l++) run_line(l == 0, LINE, (l % 2 == 0) ? 1 : 2);
      // R9: reset in mid frame, then resume
      run_line(1'b1, 10, 1);
      do_reset();
      run_line(1'b0, LINE, 0);
      for (int l = 0; l < FRAME; l++) run_line(l == 0, LINE, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule